// File: doc/BRIEF.md
# SPI Target Front End with Transfer Pause

This block is the serial front end of a memory-style SPI target that honours a pause input. A host selects the target with an active-low select, clocks command and data bits in on MOSI, and reads status bits back on MISO. A separate active-low pause input lets the host stall a transfer in the middle of a byte. During the pause the target ignores the serial clock, keeps its partial byte and releases the data output. The host can then resume exactly where it stopped.

All four serial inputs are first passed through synchronizers clocked by a system clock at least four times faster than the serial clock. Every edge and phase decision is taken on the synchronized copies. Each received byte goes out on a one-cycle strobe, with a flag that marks the first byte of a selection. A small register model uses that stream to keep a write-enable latch, which can be set, cleared and read back through a status byte. Pause entry and exit depend on the serial clock phase. If the select rises while paused, the pending command is abandoned and the latch is cleared.

Top module: `spi_hold_target`

## Requirements
- R1: MOSI is sampled MSB first on each rising serial-clock edge outside pause; after the eighth sample, rx_valid_o pulses for one system cycle with the byte on rx_byte_o, and rx_first_o is 1 only for the first byte since select fell.
- R2: When the select rises outside pause after exactly one complete byte, opcode 0x06 sets wel_o and opcode 0x04 clears it; any other opcode, more than one byte, or a trailing partial byte leaves wel_o unchanged.
- R3: After opcode 0x05, each later falling serial-clock edge drives the next bit of a status byte on miso_o, MSB first, repeated for every following byte; the status byte has wel_o in bit 1 and 0 in every other bit. miso_oe_o is 1 only in this read phase while selected and not paused.
- R4: A select rise outside pause discards a partly shifted byte without a strobe and restarts the bit count, so the next selection frames its bytes from its first bit.
- R5: While paused, miso_oe_o is 0, serial-clock edges are ignored, and the bit count and both shift registers keep their values.
- R6: A pause request seen while the serial clock is high takes effect at the next falling edge, and that falling edge is ignored.
- R7: A pause release seen while the serial clock is low ends the pause at once, and the next rising edge is sampled.
- R8: A pause release seen while the serial clock is high keeps the pause until the next low phase starts; the falling edge that starts that phase is ignored.
- R9: A select rise while paused aborts the command in progress without executing it and forces wel_o to 0.
- R10: After reset, wel_o and miso_oe_o are 0 and no byte strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low target select, asynchronous |
| hold_n_i | input | 1 | Active-low pause request, asynchronous |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for miso_o (0 = high impedance) |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_byte_o | output | 8 | Received byte |
| rx_first_o | output | 1 | Byte is the first since select fell |
| wel_o | output | 1 | Write-enable latch |

## Verification
The hardest case to reach is a pause release while the serial clock is high during a status read. The pause must survive the rest of the high phase, and the falling edge that ends it must not advance the status shifter. The stimulus reads two status bits, pauses in the low phase, raises the clock, releases the pause while the clock is high, and only then lowers it. Then it checks that miso_oe_o stayed low during the high phase and that the reassembled status byte shows no skipped bit. The abort path is reached by pausing after a full write-enable opcode and raising the select before the release, so the latch must stay clear even though the opcode arrived intact.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_LATCH_ON  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_LATCH_OFF = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_RD   = 8'h05;

  // Status byte: latch in bit 1, all other bits zero.
  function automatic logic [BYTE_W-1:0] status_byte(input logic wel);
    logic [BYTE_W-1:0] s;
    s    = '0;
    s[1] = wel;
    return s;
  endfunction

  function automatic logic last_bit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(BYTE_W - 1);
  endfunction

  // Saturating byte counter: 0, 1, 2 = two or more.
  function automatic logic [1:0] byte_cnt_next(input logic [1:0] c);
    return (c == 2'd2) ? c : c + 2'd1;
  endfunction
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  input  logic cs_rise,
  output logic hold_active,
  output logic hold_gate,
  output logic abort_evt
);
  logic enter_now;
  logic leave_now;

  // Entry only in a low phase; a request in a high phase waits for the fall.
  assign enter_now = !hold_active && !cs_n_s && !hold_n_s && !sck_s;
  // Exit only in a low phase; a release in a high phase waits for the fall.
  assign leave_now = hold_active && hold_n_s && !sck_s;

  assign hold_gate = hold_active || enter_now;
  assign abort_evt = cs_rise && hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_active <= 1'b0;
    else if (cs_n_s)     hold_active <= 1'b0;
    else if (enter_now)  hold_active <= 1'b1;
    else if (leave_now)  hold_active <= 1'b0;
  end
endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift
  import spi_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              rise_g,
  input  logic              fall_g,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [1:0]        byte_cnt,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              miso
);
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_first <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_n_s) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (rise_g) begin
        rx_sh <= {rx_sh[BYTE_W-3:0], mosi_s};
        if (last_bit(bit_cnt)) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh, mosi_s};
          rx_first <= (byte_cnt == 2'd0);
          byte_cnt <= byte_cnt_next(byte_cnt);
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      miso  <= 1'b0;
    end else if (load_en) begin
      tx_sh <= load_val;
    end else if (fall_g) begin
      miso  <= tx_sh[BYTE_W-1];
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_hold_regs.sv
module spi_hold_regs
  import spi_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              cs_rise,
  input  logic              abort_evt,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_first,
  input  logic              bit_idle,
  input  logic              one_byte,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_val,
  output logic              rd_mode,
  output logic              wel
);
  logic [BYTE_W-1:0] op_q;
  logic              exec_ok;

  assign load_en  = rx_valid && ((rx_first && rx_byte == OP_STAT_RD) || (!rx_first && rd_mode));
  assign load_val = status_byte(wel);
  assign exec_ok  = cs_rise && !abort_evt && bit_idle && one_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      rd_mode <= 1'b0;
      wel     <= 1'b0;
    end else begin
      if (cs_n_s) rd_mode <= 1'b0;
      else if (rx_valid && rx_first) begin
        op_q    <= rx_byte;
        rd_mode <= (rx_byte == OP_STAT_RD);
      end
      if (abort_evt) wel <= 1'b0;
      else if (exec_ok) begin
        if (op_q == OP_LATCH_ON)       wel <= 1'b1;
        else if (op_q == OP_LATCH_OFF) wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_hold_target.sv
module spi_hold_target
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_first_o,
  output logic              wel_o
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] SYNC_RST = 4'b0110; // mosi, hold_n, cs_n, sck

  logic [NSIG-1:0] sync_q;
  logic sck_s, cs_n_s, hold_n_s, mosi_s;
  logic sck_d, cs_n_d;
  logic sck_rise_evt, sck_fall_evt, cs_rise_evt;
  logic rise_g, fall_g;
  logic hold_active, hold_gate, abort_evt;
  logic [CNT_W-1:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic load_en, rd_mode;
  logic [BYTE_W-1:0] load_val;

  spi_hold_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mosi_i, hold_n_i, cs_n_i, sck_i}),
    .q(sync_q)
  );
  assign {mosi_s, hold_n_s, cs_n_s, sck_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sck_d  <= sck_s;
      cs_n_d <= cs_n_s;
    end
  end

  assign sck_rise_evt = sck_s && !sck_d;
  assign sck_fall_evt = !sck_s && sck_d;
  assign cs_rise_evt  = cs_n_s && !cs_n_d;

  spi_hold_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
    .hold_n_s(hold_n_s), .cs_rise(cs_rise_evt),
    .hold_active(hold_active), .hold_gate(hold_gate), .abort_evt(abort_evt)
  );

  assign rise_g = sck_rise_evt && !hold_gate && !cs_n_s;
  assign fall_g = sck_fall_evt && !hold_gate && !cs_n_s;

  spi_hold_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .rise_g(rise_g), .fall_g(fall_g), .load_en(load_en), .load_val(load_val),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .rx_valid(rx_valid_o), .rx_byte(rx_byte_o), .rx_first(rx_first_o),
    .miso(miso_o)
  );

  spi_hold_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cs_rise(cs_rise_evt),
    .abort_evt(abort_evt), .rx_valid(rx_valid_o), .rx_byte(rx_byte_o),
    .rx_first(rx_first_o), .bit_idle(bit_cnt == '0), .one_byte(byte_cnt == 2'd1),
    .load_en(load_en), .load_val(load_val), .rd_mode(rd_mode), .wel(wel_o)
  );

  assign miso_oe_o = rd_mode && !cs_n_s && !hold_gate;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk
  import spi_hold_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sck_s,
  input logic             cs_n_s,
  input logic             hold_n_s,
  input logic             hold_active,
  input logic             abort_evt,
  input logic             cs_rise_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             wel_o,
  input logic             miso_oe_o,
  input logic             rx_valid_o
);
  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_wel_only_at_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_o != $past(wel_o)) |-> $past(cs_rise_evt));

  assert_oe_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !miso_oe_o);

  assert_pause_releases_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !miso_oe_o);

  assert_pause_freezes_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !cs_n_s) |=> $stable(bit_cnt));

  assert_low_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && hold_n_s && !sck_s && !cs_n_s) |=> !hold_active);

  assert_high_release_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && sck_s && !cs_n_s) |=> hold_active);

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !wel_o);
endmodule

bind spi_hold_target spi_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
  .hold_active(hold_active), .abort_evt(abort_evt), .cs_rise_evt(cs_rise_evt),
  .bit_cnt(bit_cnt), .wel_o(wel_o), .miso_oe_o(miso_oe_o), .rx_valid_o(rx_valid_o)
);

// File: tb/spi_hold_target_bench.sv
module spi_hold_target_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
  logic miso_o, miso_oe_o, rx_valid_o, rx_first_o, wel_o;
  logic [7:0] rx_byte_o;

  int n_tests = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic last_first = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_hold_target u_spi_hold_target (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .mosi_i(mosi), .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rx_valid_o(rx_valid_o),
    .rx_byte_o(rx_byte_o), .rx_first_o(rx_first_o), .wel_o(wel_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) begin
      rx_cnt++;
      last_byte = rx_byte_o;
      last_first = rx_first_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic set_sck(input logic v);
    @(negedge clk) sck = v;
    wait_half();
  endtask

  task automatic set_hold(input logic v);
    @(negedge clk) hold_n = v;
    wait_half();
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    wait_half();
  endtask

  task automatic desel();
    set_sck(1'b0);
    @(negedge clk) cs_n = 1'b1;
    wait_half();
    wait_half();
  endtask

  // Bits hi..lo, MSB first; MISO sampled at the end of each low phase.
  task automatic xfer(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk) begin sck = 1'b0; mosi = tx[i]; end
      wait_half();
      rx[i] = miso_o;
      @(negedge clk) sck = 1'b1;
      wait_half();
    end
  endtask

  task automatic one_byte_txn(input logic [7:0] tx);
    logic [7:0] rx = 8'h00;
    sel();
    xfer(tx, 7, 0, rx);
    desel();
  endtask

  task automatic read_status(output logic [7:0] st, output logic oe_seen);
    logic [7:0] rx = 8'h00;
    sel();
    xfer(8'h05, 7, 0, rx);
    oe_seen = miso_oe_o;
    xfer(8'h00, 7, 0, rx);
    st = rx;
    desel();
  endtask

  // {opcode, expected latch afterwards}
  localparam logic [8:0] VEC [0:5] = '{
    {8'h06, 1'b1}, {8'h04, 1'b0}, {8'h06, 1'b1},
    {8'hAB, 1'b1}, {8'h05, 1'b1}, {8'h04, 1'b0}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] st;
    logic [7:0] rx;
    logic oe;
    int base;
    rx = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 wel", wel_o, 0);
    chk("R10 oe", miso_oe_o, 0);
    chk("R10 no strobe", rx_cnt, 0);

    // R1 / R2 table walk
    foreach (VEC[k]) begin
      base = rx_cnt;
      one_byte_txn(VEC[k][8:1]);
      chk("R2 latch after opcode", wel_o, VEC[k][0]);
      chk("R1 byte value", last_byte, VEC[k][8:1]);
      chk("R1 first flag", last_first, 1);
      chk("R1 one strobe", rx_cnt - base, 1);
    end

    // R3 status read with latch clear then set
    read_status(st, oe);
    chk("R3 status latch clear", st, 8'h00);
    chk("R3 oe in read", oe, 1);
    one_byte_txn(8'h06);
    read_status(st, oe);
    chk("R3 status latch set", st, 8'h02);
    chk("R3 oe after deselect", miso_oe_o, 0);

    // R2 two bytes: no execution; R1 second byte not first
    sel();
    xfer(8'h04, 7, 0, rx);
    xfer(8'h00, 7, 0, rx);
    desel();
    chk("R2 multi-byte ignored", wel_o, 1);
    chk("R1 second byte flag", last_first, 0);

    // R4 partial byte discarded, framing restarts
    base = rx_cnt;
    sel();
    xfer(8'h04, 7, 3, rx);
    desel();
    chk("R4 no strobe on partial", rx_cnt - base, 0);
    chk("R4 latch unchanged", wel_o, 1);
    one_byte_txn(8'h04);
    chk("R4 reframed byte", last_byte, 8'h04);
    chk("R4 reframed exec", wel_o, 0);

    // R5 / R7 pause in low phase, clock ignored, release in low phase
    base = rx_cnt;
    sel();
    xfer(8'h06, 7, 4, rx);
    set_sck(1'b0);
    set_hold(1'b0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk) mosi = ~mosi;
      set_sck(1'b1);
      set_sck(1'b0);
    end
    chk("R5 no strobe while paused", rx_cnt - base, 0);
    set_hold(1'b1);
    xfer(8'h06, 3, 0, rx);
    desel();
    chk("R7 byte intact", last_byte, 8'h06);
    chk("R7 latch set", wel_o, 1);

    // R8 release during high phase within a status read
    rx = 8'h00;
    sel();
    xfer(8'h05, 7, 0, rx);
    xfer(8'h00, 7, 6, rx);
    set_sck(1'b0);
    set_hold(1'b0);
    chk("R5 oe off in pause", miso_oe_o, 0);
    set_sck(1'b1);
    set_hold(1'b1);
    chk("R8 still paused in high phase", miso_oe_o, 0);
    set_sck(1'b0);
    chk("R8 resumed in low phase", miso_oe_o, 1);
    xfer(8'h00, 5, 0, rx);
    desel();
    chk("R8 no skipped status bit", rx, 8'h02);

    // R6 request in high phase takes effect at the fall
    sel();
    xfer(8'h04, 7, 4, rx);
    set_hold(1'b0);
    set_sck(1'b0);
    @(negedge clk) mosi = ~mosi;
    set_sck(1'b1);
    set_sck(1'b0);
    set_hold(1'b1);
    xfer(8'h04, 3, 0, rx);
    desel();
    chk("R6 byte intact", last_byte, 8'h04);
    chk("R6 latch cleared", wel_o, 0);

    // R9 abort after complete opcode
    sel();
    xfer(8'h06, 7, 0, rx);
    set_sck(1'b0);
    set_hold(1'b0);
    @(negedge clk) cs_n = 1'b1;
    wait_half();
    set_hold(1'b1);
    chk("R9 aborted opcode not run", wel_o, 0);

    // R9 abort mid-byte clears a set latch
    one_byte_txn(8'h06);
    chk("R9 latch set before abort", wel_o, 1);
    sel();
    xfer(8'h00, 7, 5, rx);
    set_sck(1'b0);
    set_hold(1'b0);
    @(negedge clk) cs_n = 1'b1;
    wait_half();
    set_hold(1'b1);
    chk("R9 abort clears latch", wel_o, 0);
    one_byte_txn(8'h06);
    chk("R9 normal after abort", wel_o, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule